// File: doc/BRIEF.md
# Serial Flash Streaming Read Engine

This block is the host side of a single-bit SPI link to a serial flash. It performs streaming reads. A requester gives a start address, a byte count and a choice of 24-bit or 32-bit addressing. The engine pulls chip select low and sends the read opcode and then the address on the serial data output. It then clocks in the bytes the flash returns and hands each complete byte to a downstream consumer over a valid/ready stream.

The engine addresses the flash only once per request. The flash advances its own address after every byte, so any number of sequential bytes follow the single command. The serial clock is made from the system clock by a divider and idles low (SPI mode 0). If the consumer stalls, the serial clock stops between bytes and chip select stays low. A transfer ends with a one-cycle done pulse, either when the last byte is taken or when an abort is requested. After that, chip select is held high for a minimum time before the next request is taken.

Top module: `spi_rd_host`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, no byte is offered, done is low and the request port is ready.
- R2: Accepting a request with a non-zero count drives chip select low in the next cycle. The serial clock stays low for HALF_DIV system cycles before its first rising edge. Every high phase of the serial clock lasts exactly HALF_DIV cycles, and the clock is always low while chip select is high.
- R3: The first 8 bits shifted out are the opcode 0x03, most significant bit first. The serial data output changes only after a falling edge, so it is stable for the whole time the serial clock is high.
- R4: With the 32-bit select low, the 24 address bits after the opcode are req_addr[23:0] and req_addr[31:24] is ignored. With the select high, req_addr[31:0] is sent, MSB first.
- R5: Input data is sampled on rising edges, MSB first. A transfer of N bytes uses exactly 8 + address bits + 8*N rising edges, with no second command or address.
- R6: A byte is offered only after all 8 bits are captured. While it is offered and not taken, rd_data stays stable, the serial clock is low and chip select stays low.
- R7: In the cycle after the handshake of the last requested byte, chip select goes high and done is high for exactly one cycle.
- R8: An abort during a transfer raises chip select and pulses done in the next cycle. A partially received byte is never offered. A byte held waiting is not offered in the cycle the abort is high.
- R9: From the cycle chip select rises, the request port stays not-ready for CS_GAP cycles.
- R10: A request with a count of zero pulses done without lowering chip select, and the port stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_addr | input | 32 | Start byte address |
| req_len | input | LEN_W | Number of bytes to read |
| req_addr4 | input | 1 | 1 selects a 32-bit address phase, 0 a 24-bit one |
| abort | input | 1 | End the current transfer at once |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data holds a complete byte |
| rd_ready | input | 1 | Consumer takes the byte |
| done | output | 1 | One-cycle end-of-transfer pulse |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The assertions assume two things. The flash changes spi_miso only after a falling edge of the serial clock. Abort is a single-cycle request and is never raised in the same cycle as the final handshake. The bench meets the first by modelling the flash so that it updates its output bit one system cycle after it sees the serial clock fall, which is well inside the HALF_DIV cycles before the next rise. It meets the second by raising abort only mid-byte, or while a byte is held and the consumer is stalled.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_HOLD,
    ST_GAP
  } rd_state_e;

  localparam int FRAME_W = 40;
endpackage

// File: rtl/spi_rd_tick.sv
module spi_rd_tick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          last;

  assign last = (cnt_q == CW'(HALF_DIV - 1));
  assign tick = run & last;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)      cnt_d = '0;
    else if (last) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_rd_shreg.sv
module spi_rd_shreg #(
  parameter int FRAME_W = 40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_val,
  input  logic               shift_tx,
  input  logic               cap_rx,
  input  logic               miso,
  output logic               mosi,
  output logic [7:0]         rx_byte
);
  logic [FRAME_W-1:0] tx_q, tx_d;
  logic [7:0]         rx_q, rx_d;

  always_comb begin
    tx_d = tx_q;
    if (load)          tx_d = load_val;
    else if (shift_tx) tx_d = {tx_q[FRAME_W-2:0], 1'b0};
  end

  always_comb begin
    rx_d = rx_q;
    if (cap_rx) rx_d = {rx_q[6:0], miso};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign mosi    = tx_q[FRAME_W-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_rd_host.sv
module spi_rd_host
  import spi_rd_pkg::*;
#(
  parameter int        HALF_DIV = 2,
  parameter int        CS_GAP   = 4,
  parameter int        LEN_W    = 16,
  parameter logic [7:0] OPCODE  = 8'h03
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_addr4,
  input  logic             abort,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             done,
  output logic             spi_cs_n,
  output logic             spi_sck,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int BIT_W = $clog2(FRAME_W + 1);
  localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;

  rd_state_e        state_q, state_d;
  logic             sck_q, sck_d;
  logic             cs_n_q, cs_n_d;
  logic             done_q, done_d;
  logic [BIT_W-1:0] bits_q, bits_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  logic               run, tick, rise_ev, fall_ev, start;
  logic [FRAME_W-1:0] frame;

  assign run     = (state_q == ST_CMD) || (state_q == ST_DATA);
  assign rise_ev = tick & ~sck_q;
  assign fall_ev = tick & sck_q;
  assign start   = (state_q == ST_IDLE) && req_valid && (req_len != '0);
  assign frame   = req_addr4 ? {OPCODE, req_addr} : {OPCODE, req_addr[23:0], 8'h00};

  spi_rd_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  spi_rd_shreg #(.FRAME_W(FRAME_W)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (start),
    .load_val(frame),
    .shift_tx(fall_ev && (state_q == ST_CMD)),
    .cap_rx  (rise_ev && (state_q == ST_DATA)),
    .miso    (spi_miso),
    .mosi    (spi_mosi),
    .rx_byte (rd_data)
  );

  always_comb begin
    state_d = state_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    done_d  = 1'b0;
    bits_d  = bits_q;
    left_d  = left_q;
    gap_d   = gap_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_len == '0) begin
            done_d = 1'b1;
          end else begin
            state_d = ST_CMD;
            cs_n_d  = 1'b0;
            bits_d  = req_addr4 ? BIT_W'(40) : BIT_W'(32);
            left_d  = req_len;
          end
        end
      end
      ST_CMD, ST_DATA: begin
        if (abort) begin
          state_d = ST_GAP;
          cs_n_d  = 1'b1;
          sck_d   = 1'b0;
          done_d  = 1'b1;
          gap_d   = GAP_W'(CS_GAP - 1);
        end else if (rise_ev) begin
          sck_d = 1'b1;
        end else if (fall_ev) begin
          sck_d  = 1'b0;
          bits_d = bits_q - 1'b1;
          if (bits_q == BIT_W'(1)) begin
            if (state_q == ST_CMD) begin
              state_d = ST_DATA;
              bits_d  = BIT_W'(8);
            end else begin
              state_d = ST_HOLD;
            end
          end
        end
      end
      ST_HOLD: begin
        if (abort || (rd_ready && left_q == LEN_W'(1))) begin
          state_d = ST_GAP;
          cs_n_d  = 1'b1;
          done_d  = 1'b1;
          gap_d   = GAP_W'(CS_GAP - 1);
        end else if (rd_ready) begin
          state_d = ST_DATA;
          left_d  = left_q - 1'b1;
          bits_d  = BIT_W'(8);
        end
      end
      ST_GAP: begin
        if (gap_q == '0) state_d = ST_IDLE;
        else             gap_d   = gap_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      bits_q  <= '0;
      left_q  <= '0;
      gap_q   <= '0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      bits_q  <= bits_d;
      left_q  <= left_d;
      gap_q   <= gap_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign rd_valid  = (state_q == ST_HOLD) && !abort;
  assign done      = done_q;
  assign spi_cs_n  = cs_n_q;
  assign spi_sck   = sck_q;

  // Serial clock parked low whenever the flash is deselected (R2).
  p_sck_low_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  // Output bit only moves after a falling edge (R3).
  p_mosi_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  // Held byte stays put until taken (R6).
  p_byte_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> ((rd_valid || abort) && $stable(rd_data)));

  // Clock paused and device selected while a byte waits (R6).
  p_pause_selected_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!spi_sck && !spi_cs_n));

  // Done lasts one cycle (R7).
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // Abort releases the device and signals completion (R8).
  p_abort_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !spi_cs_n) |=> (spi_cs_n && done));

  // No new request in the cycle chip select rises (R9).
  p_gap_after_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> !req_ready);
endmodule

// File: tb/spi_rd_host_tb.sv
module spi_rd_host_tb;
  localparam int H     = 2;
  localparam int GAP   = 4;
  localparam int LEN_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [31:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic             req_addr4 = 1'b0;
  logic             abort = 1'b0;
  logic [7:0]       rd_data;
  logic             rd_valid;
  logic             rd_ready = 1'b0;
  logic             done;
  logic             cs_n, sck, mosi;
  logic             miso = 1'b0;

  int tests = 0;
  int fails = 0;
  int cyc_all = 0;

  spi_rd_host #(.HALF_DIV(H), .CS_GAP(GAP), .LEN_W(LEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_addr4(req_addr4), .abort(abort),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .done(done),
    .spi_cs_n(cs_n), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_at(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ a[31:24] ^ 8'h3C;
  endfunction

  // Flash model and per-clock protocol monitor
  int          rise_cnt = 0;
  int          aw_m = 24;
  logic [31:0] base_m = '0;
  logic [39:0] cmd_sh = '0;
  logic        prev_sck = 1'b0, prev_cs = 1'b1, mosi_r = 1'b0;
  int          hi_len = 0, lo_len = 0;
  bit          first_pend = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(!(cs_n && sck), "R2 sck low while deselected", sck, 0);
      if (rd_valid) check(!sck && !cs_n, "R6 paused and selected", {cs_n, sck}, 0);
      if (prev_cs && !cs_n) begin
        rise_cnt = 0; cmd_sh = '0; first_pend = 1'b1; lo_len = 1;
      end else if (!cs_n && prev_sck == 1'b0 && sck == 1'b1) begin
        if (first_pend) check(lo_len == H, "R2 first low phase", lo_len, H);
        first_pend = 1'b0;
        if (rise_cnt < 8 + aw_m) cmd_sh = {cmd_sh[38:0], mosi};
        rise_cnt++;
        mosi_r = mosi; hi_len = 1;
      end else if (!cs_n && prev_sck == 1'b1 && sck == 1'b0) begin
        int n;
        logic [31:0] cur;
        check(hi_len == H, "R2 high phase", hi_len, H);
        n = rise_cnt - (8 + aw_m);
        if (n >= 0) begin
          cur = base_m + 32'(n / 8);
          if (aw_m == 24) cur[31:24] = 8'h00;
          miso = mem_at(cur)[7 - (n % 8)];
        end
      end else if (!cs_n && sck) begin
        check(mosi == mosi_r, "R3 mosi stable while sck high", mosi, mosi_r);
        hi_len++;
      end else if (!cs_n && first_pend) begin
        lo_len++;
      end
    end
    prev_sck = sck;
    prev_cs  = cs_n;
  end

  task automatic run_read(input logic [31:0] a, input int n, input bit a4,
                          input int rmode, input int ab_byte, input bit ab_hold);
    int got = 0;
    int cyc = 0;
    int gap;
    bit aborted = 1'b0;
    bit r, ab;
    bit last_r = 1'b0, last_ab = 1'b0, pv_v = 1'b0;
    logic [7:0]  pv_d = '0;
    logic [31:0] ea;
    base_m = a;
    aw_m   = a4 ? 32 : 24;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = LEN_W'(n); req_addr4 = a4;
    @(negedge clk);
    req_valid = 1'b0;
    if (n == 0) begin
      check(done && cs_n && req_ready, "R10 zero length", {done, cs_n, req_ready}, 3'b111);
      @(negedge clk);
      check(!done && cs_n, "R10 single pulse, no select", {done, cs_n}, 2'b01);
      return;
    end
    check(!cs_n, "R2 select after accept", cs_n, 0);
    check(!req_ready, "R9 busy while active", req_ready, 0);
    while (!done && cyc < 20000) begin
      if (pv_v && !last_r && !last_ab)
        check(rd_valid && rd_data == pv_d, "R6 byte held", rd_data, pv_d);
      r  = (rmode == 0) ? 1'b1 : (rmode == 1) ? cyc[0] : (cyc % 7 == 0);
      ab = 1'b0;
      if (!aborted && ab_byte >= 0 && got == ab_byte) begin
        int part;
        part = rise_cnt - (8 + aw_m) - 8 * got;
        if (ab_hold && rd_valid && !r) ab = 1'b1;
        if (!ab_hold && !rd_valid && part >= 3 && part <= 6) ab = 1'b1;
      end
      if (rd_valid && r && !ab) begin
        ea = a + 32'(got);
        if (!a4) ea[31:24] = 8'h00;
        check(rd_data == mem_at(ea), "R5 data byte", rd_data, mem_at(ea));
        got++;
      end
      pv_v = rd_valid; pv_d = rd_data; last_r = r; last_ab = ab;
      rd_ready = r; abort = ab;
      if (ab) aborted = 1'b1;
      @(negedge clk);
      cyc++;
      abort = 1'b0;
    end
    check(done, "R7 done seen", done, 1);
    check(cs_n && !rd_valid, "R8 deselect at end", {cs_n, rd_valid}, 2'b10);
    if (aborted) begin
      check(got == ab_byte, "R8 no partial byte", got, ab_byte);
    end else begin
      check(got == n, "R7 byte count", got, n);
      check(rise_cnt == 8 + aw_m + 8 * n, "R5 rising edges", rise_cnt, 8 + aw_m + 8 * n);
      if (a4) check(cmd_sh == {8'h03, a}, "R4 32-bit command", cmd_sh, {8'h03, a});
      else    check(cmd_sh[31:0] == {8'h03, a[23:0]}, "R4 24-bit command",
                    cmd_sh[31:0], {8'h03, a[23:0]});
      check(cmd_sh[aw_m +: 8] == 8'h03, "R3 opcode", cmd_sh[aw_m +: 8], 8'h03);
    end
    rd_ready = 1'b0;
    gap = 1;
    @(negedge clk);
    check(!done, "R7 done one cycle", done, 0);
    while (!req_ready && gap < 100) begin
      gap++;
      @(negedge clk);
    end
    check(gap == GAP, "R9 deselect gap", gap, GAP);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc_all++;
      if (cyc_all > 150000) begin
        fails++;
        tests++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc_all, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(cs_n && !sck && !rd_valid && !done && req_ready, "R1 reset state",
          {cs_n, sck, rd_valid, done, req_ready}, 5'b10001);
    run_read(32'h0000_1230, 3, 1'b0, 0, -1, 1'b0);
    run_read(32'h8000_00F0, 5, 1'b1, 1, -1, 1'b0);
    run_read(32'hAB_FFFFFE, 4, 1'b0, 2, -1, 1'b0);
    run_read(32'h0004_0000, 6, 1'b0, 0, 2, 1'b0);
    run_read(32'h1234_5678, 6, 1'b1, 2, 1, 1'b1);
    run_read(32'h0000_0010, 0, 1'b0, 0, -1, 1'b0);
    run_read(32'h00FF_FFFF, 1, 1'b1, 0, -1, 1'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule